// File: doc/BRIEF.md
# Jump and Conditional Branch Unit

This block resolves control flow for a small processor whose words and program counter are 24 bits wide. It handles the jump group and the conditional branch group. Each cycle it takes an instruction word, the current program counter, one register value and the four condition flags. One clock edge later it presents the next program counter and, for the linking forms, a write of the return address into the link register (register 15). The program counter counts in instruction words, so the sequential successor of `pc` is `pc + 1`.

The instruction word carries a major opcode in bits 23:20 and a sub-opcode in bits 19:16. Bits 15:12 name a register. The register file outside the block reads that register and supplies its value on `regVal`. Bits 11:0 hold a long signed displacement, and bits 7:0 hold a short signed displacement. Every relative target is `pc` plus the sign-extended displacement, and all address arithmetic wraps modulo 2^24.

Top module: `jump_branch_unit`

## Requirements
- R1: While `rstN` is low, `nextPc`, `linkWe` and `linkVal` are all zero. Every output is registered, so it reflects the inputs present at the previous rising edge of `clk`.
- R2: Major opcode 0 with sub-opcode 0 gives `nextPc = pc + sext(instr[11:0])` and `linkWe = 0`.
- R3: Major opcode 0 with sub-opcode 8 gives `nextPc = pc + sext(instr[7:0])` and `linkWe = 0`.
- R4: Major opcode 0 with sub-opcode 1 gives `nextPc = regVal` and `linkWe = 0`.
- R5: Major opcode 0 with sub-opcodes 2, 3 and A are the linking forms. They set `linkWe = 1` and `linkVal = pc + 1`. Their targets are:
  - sub-opcode 2: `pc + sext(instr[11:0])`
  - sub-opcode 3: `regVal`
  - sub-opcode A: `pc + sext(instr[7:0])`
- R6: Sub-opcode 3 with register field 15 takes its target from the incoming `regVal`, which is the old value of register 15. In the same cycle it still delivers the link value `pc + 1`.
- R7: Major opcode 8 with sub-opcodes 0 to 7 are the long branches. With flags = {N,Z,V,C} in bits 3..0, the conditions are:
  - 0: Z
  - 1: !Z
  - 2: N
  - 3: !N
  - 4: V
  - 5: !V
  - 6: C
  - 7: !C

  A branch whose condition holds gives `nextPc = pc + sext(instr[11:0])`.
- R8: Major opcode 8 with sub-opcodes 8 to F are the short branches. They test the condition of sub-opcode minus 8 and, when it holds, give `nextPc = pc + sext(instr[7:0])`.
- R9: A branch whose condition fails gives `nextPc = pc`. No branch ever sets `linkWe`.
- R10: Every other major opcode, and jump sub-opcodes 4 to 7, 9 and B to F, give `nextPc = pc + 1` and `linkWe = 0`.
- R11: Target and link arithmetic wraps modulo 2^24. For example, `pc = FFFFFF` with a sequential instruction gives 000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| instr | input | 24 | Instruction word |
| pc | input | PC_W (24) | Current program counter |
| regVal | input | PC_W (24) | Value of the register named by instr[15:12] |
| flags | input | 4 | Condition flags {N,Z,V,C} |
| nextPc | output | PC_W (24) | Registered next program counter |
| linkWe | output | 1 | Registered link-register write enable |
| linkVal | output | PC_W (24) | Registered value for register 15 |

## Verification
Jump-and-link to register is the one case where a register-indirect target and a link write happen in the same cycle. It matters most when the target register is register 15 itself. The bench provokes this case by encoding register field 15 with a `regVal` that differs from `pc + 1`. It then judges that `nextPc` carries the old register value while `linkVal` carries `pc + 1`. A sweep over all major opcodes, sub-opcodes and flag patterns, with varying displacements, also checks that every branch condition picks between the held PC and the right displacement width.

// File: rtl/jbu_pkg.sv
package jbu_pkg;
  localparam int INSTR_W = 24;
  localparam logic [3:0] OP_JUMP   = 4'h0;
  localparam logic [3:0] OP_BRANCH = 4'h8;

  typedef enum logic [2:0] {
    TGT_SEQ,
    TGT_HOLD,
    TGT_LONG,
    TGT_SHORT,
    TGT_REG
  } tgtSel_e;

  typedef struct packed {
    tgtSel_e tgtSel;
    logic    linkEn;
  } jbuStrobe_t;
endpackage

// File: rtl/jbu_ctrl.sv
module jbu_ctrl
  import jbu_pkg::*;
(
  input  logic [3:0]  opMajor,
  input  logic [3:0]  opSub,
  input  logic [3:0]  flags,
  output jbuStrobe_t  strobe
);
  // flags = {N,Z,V,C}; condition pair index opSub[2:1]: 0 Z, 1 N, 2 V, 3 C
  logic [3:0] flagByPair;
  logic       condMet;

  assign flagByPair = {flags[0], flags[1], flags[3], flags[2]};
  assign condMet    = flagByPair[opSub[2:1]] ^ opSub[0];

  always_comb begin
    strobe.tgtSel = TGT_SEQ;
    strobe.linkEn = 1'b0;
    case (opMajor)
      OP_JUMP: begin
        case (opSub)
          4'h0: strobe.tgtSel = TGT_LONG;
          4'h1: strobe.tgtSel = TGT_REG;
          4'h2: begin strobe.tgtSel = TGT_LONG;  strobe.linkEn = 1'b1; end
          4'h3: begin strobe.tgtSel = TGT_REG;   strobe.linkEn = 1'b1; end
          4'h8: strobe.tgtSel = TGT_SHORT;
          4'hA: begin strobe.tgtSel = TGT_SHORT; strobe.linkEn = 1'b1; end
          default: ;
        endcase
      end
      OP_BRANCH: begin
        if (condMet) strobe.tgtSel = opSub[3] ? TGT_SHORT : TGT_LONG;
        else         strobe.tgtSel = TGT_HOLD;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/jbu_datapath.sv
module jbu_datapath
  import jbu_pkg::*;
#(
  parameter int PC_W = 24
) (
  input  logic            clk,
  input  logic            rstN,
  input  jbuStrobe_t      strobe,
  input  logic [11:0]     dispField,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] regVal,
  output logic [PC_W-1:0] nextPc,
  output logic            linkWe,
  output logic [PC_W-1:0] linkVal
);
  localparam int LONG_W  = 12;
  localparam int SHORT_W = 8;

  logic [PC_W-1:0] longOff, shortOff, seqPc, target;

  assign longOff  = {{(PC_W-LONG_W){dispField[LONG_W-1]}}, dispField};
  assign shortOff = {{(PC_W-SHORT_W){dispField[SHORT_W-1]}}, dispField[SHORT_W-1:0]};
  assign seqPc    = pc + PC_W'(1);

  // Register target is latched from regVal before the link write lands.
  always_comb begin
    case (strobe.tgtSel)
      TGT_HOLD:  target = pc;
      TGT_LONG:  target = pc + longOff;
      TGT_SHORT: target = pc + shortOff;
      TGT_REG:   target = regVal;
      default:   target = seqPc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextPc  <= '0;
      linkWe  <= 1'b0;
      linkVal <= '0;
    end else begin
      nextPc  <= target;
      linkWe  <= strobe.linkEn;
      linkVal <= seqPc;
    end
  end
endmodule

// File: rtl/jump_branch_unit.sv
module jump_branch_unit
  import jbu_pkg::*;
#(
  parameter int PC_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [PC_W-1:0]     pc,
  input  logic [PC_W-1:0]     regVal,
  input  logic [3:0]          flags,
  output logic [PC_W-1:0]     nextPc,
  output logic                linkWe,
  output logic [PC_W-1:0]     linkVal
);
  jbuStrobe_t strobe;

  jbu_ctrl ctrl_i (
    .opMajor (instr[23:20]),
    .opSub   (instr[19:16]),
    .flags   (flags),
    .strobe  (strobe)
  );

  jbu_datapath #(.PC_W(PC_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dispField (instr[11:0]),
    .pc        (pc),
    .regVal    (regVal),
    .nextPc    (nextPc),
    .linkWe    (linkWe),
    .linkVal   (linkVal)
  );
endmodule

// File: rtl/jump_branch_unit_chk.sv
module jump_branch_unit_chk #(
  parameter int PC_W = 24
) (
  input logic            clk,
  input logic            rstN,
  input logic [23:0]     instr,
  input logic [PC_W-1:0] pc,
  input logic [PC_W-1:0] regVal,
  input logic [3:0]      flags,
  input logic [PC_W-1:0] nextPc,
  input logic            linkWe,
  input logic [PC_W-1:0] linkVal
);
  logic isJump, isBranch, flagSel, branchFails;
  assign isJump   = instr[23:20] == 4'h0;
  assign isBranch = instr[23:20] == 4'h8;
  always_comb begin
    case (instr[18:17])
      2'd0: flagSel = flags[2];
      2'd1: flagSel = flags[3];
      2'd2: flagSel = flags[1];
      default: flagSel = flags[0];
    endcase
  end
  assign branchFails = isBranch && (flagSel == instr[16]);

  assert_seq_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!isJump && !isBranch) |=> (nextPc == PC_W'($past(pc) + 1) && !linkWe));

  assert_regjump_R4: assert property (@(posedge clk) disable iff (!rstN)
    (isJump && instr[19:16] == 4'h1) |=> (nextPc == $past(regVal) && !linkWe));

  assert_linkval_R5: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> linkVal == PC_W'($past(pc) + 1));

  assert_selflink_R6: assert property (@(posedge clk) disable iff (!rstN)
    (isJump && instr[19:16] == 4'h3 && instr[15:12] == 4'hF)
      |=> (nextPc == $past(regVal) && linkWe));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    branchFails |=> (nextPc == $past(pc) && !linkWe));
endmodule

bind jump_branch_unit jump_branch_unit_chk #(.PC_W(PC_W)) chk_i (
  .clk(clk), .rstN(rstN), .instr(instr), .pc(pc), .regVal(regVal),
  .flags(flags), .nextPc(nextPc), .linkWe(linkWe), .linkVal(linkVal)
);

// File: tb/jump_branch_unit_tb_top.sv
module jump_branch_unit_tb_top;
  localparam int PC_W = 24;
  localparam time HALF = 5ns;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [23:0]     instr = '0;
  logic [PC_W-1:0] pc = '0;
  logic [PC_W-1:0] regVal = '0;
  logic [3:0]      flags = '0;
  logic [PC_W-1:0] nextPc;
  logic            linkWe;
  logic [PC_W-1:0] linkVal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #HALF clk = ~clk;

  jump_branch_unit #(.PC_W(PC_W)) dut_i (
    .clk(clk), .rstN(rstN), .instr(instr), .pc(pc), .regVal(regVal),
    .flags(flags), .nextPc(nextPc), .linkWe(linkWe), .linkVal(linkVal)
  );

  task automatic model(input logic [23:0] ins, input logic [23:0] p, input logic [23:0] r,
                       input logic [3:0] f, output logic [23:0] np, output logic we,
                       output logic [23:0] lv, output string tag);
    logic [23:0] s12, s8;
    logic bitv;
    s12 = {{12{ins[11]}}, ins[11:0]};
    s8  = {{16{ins[7]}}, ins[7:0]};
    np = p + 24'd1; we = 1'b0; lv = p + 24'd1; tag = "R10";
    if (ins[23:20] == 4'h0) begin
      case (ins[19:16])
        4'h0: begin np = p + s12; tag = "R2"; end
        4'h1: begin np = r; tag = "R4"; end
        4'h2: begin np = p + s12; we = 1'b1; tag = "R5"; end
        4'h3: begin np = r; we = 1'b1; tag = (ins[15:12] == 4'hF) ? "R6" : "R5"; end
        4'h8: begin np = p + s8; tag = "R3"; end
        4'hA: begin np = p + s8; we = 1'b1; tag = "R5"; end
        default: ;
      endcase
    end else if (ins[23:20] == 4'h8) begin
      case (ins[18:17])
        2'd0: bitv = f[2];
        2'd1: bitv = f[3];
        2'd2: bitv = f[1];
        default: bitv = f[0];
      endcase
      if (bitv ^ ins[16]) begin
        np = p + (ins[19] ? s8 : s12);
        tag = ins[19] ? "R8" : "R7";
      end else begin
        np = p; tag = "R9";
      end
    end
  endtask

  task automatic check(input string tag, input logic [23:0] expPc, input logic expWe,
                       input logic [23:0] expLv);
    checks++;
    if (nextPc !== expPc || linkWe !== expWe || (expWe && linkVal !== expLv)) begin
      errors++;
      $display("FAIL %s: nextPc=%h linkWe=%b linkVal=%h expected nextPc=%h linkWe=%b linkVal=%h",
               tag, nextPc, linkWe, linkVal, expPc, expWe, expLv);
    end
  endtask

  task automatic apply(input logic [23:0] ins, input logic [23:0] p, input logic [23:0] r,
                       input logic [3:0] f, input string overrideTag);
    logic [23:0] np, lv;
    logic we;
    string tag;
    @(negedge clk);
    instr = ins; pc = p; regVal = r; flags = f;
    model(ins, p, r, f, np, we, lv, tag);
    if (overrideTag != "") tag = overrideTag;
    @(posedge clk);
    #1;
    check(tag, np, we, lv);
  endtask

  initial begin
    // R1: reset state
    instr = 24'h0A0123; pc = 24'h123456; regVal = 24'h777777;
    repeat (3) @(posedge clk);
    #1;
    check("R1", 24'h0, 1'b0, 24'h0);
    @(negedge clk);
    rstN = 1'b1;

    // Near-exhaustive sweep: every major/sub opcode and flag pattern
    for (int op = 0; op < 16; op++) begin
      for (int sb = 0; sb < 16; sb++) begin
        for (int fl = 0; fl < 16; fl++) begin
          logic [23:0] ins, p, r;
          logic [11:0] d;
          d   = 12'((op * 37 + sb * 113 + fl * 251) ^ (fl[0] ? 12'h800 : 12'h080));
          ins = {op[3:0], sb[3:0], 4'(fl + sb), d};
          p   = 24'(24'h400000 + op * 24'h01F3A5 + sb * 24'h000D17 + fl * 24'h100);
          r   = 24'(24'hABC000 ^ (op * 24'h1111 + fl * 24'h31));
          apply(ins, p, r, fl[3:0], "");
        end
      end
    end

    // R6: link-to-register where the target register is register 15
    apply(24'h03F000, 24'h000100, 24'h00ABCD, 4'h0, "R6");
    apply(24'h03F000, 24'hFFFFFF, 24'h000050, 4'hF, "R6");

    // R11: wrap-around of every arithmetic path
    apply(24'h500000, 24'hFFFFFF, 24'h0, 4'h0, "R11");
    apply(24'h000FFF, 24'h000000, 24'h0, 4'h0, "R11");
    apply(24'h00007F, 24'hFFFFF0, 24'h0, 4'h0, "R11");
    apply(24'h080080, 24'h000010, 24'h0, 4'h0, "R11");
    apply(24'h020005, 24'hFFFFFF, 24'h0, 4'h0, "R11");
    apply(24'h8807F0, 24'hFFFFFE, 24'h0, 4'h4, "R11");

    // R1: re-entering reset clears a pending link write
    @(negedge clk);
    instr = 24'h020001; pc = 24'h000010;
    @(posedge clk);
    #1;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1", 24'h0, 1'b0, 24'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(HALF * 2 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule